// File: doc/BRIEF.md
# Three-Pin GPIO Port with Analog Override

This block is a small general-purpose I/O port with three pins. It sits on a simple processor register bus. Two write strobes load its output-value register and its direction register from an 8-bit write bus. A select line picks which of the two registers is returned on the registered read bus. Each pin has a direction bit, and the driver for a pin is enabled only while that bit is 0. Pin inputs pass through a two-flop synchronizer before they reach the read path.

An external configuration field supplies a per-pin analog-select mask. A pin marked analog reads back as 0 from the value register. Its driver is still governed only by the direction bit, so software must keep analog pins configured as inputs.

A mode bit in the direction register turns the three pins into active-low control inputs for a parallel slave port. While this mode is on, all drivers are switched off and the synchronized pin levels are forwarded on a dedicated control output.

Top module: `gpio3_port`

## Requirements
- R1: After reset, a read of the direction register (rd_sel=1) returns 0x07, which means all direction bits are 1 and the mode bit is 0. pin_oe is 3'b000 and slave_ctl is 3'b111.
- R2: A direction write stores wdata[2:0] as the direction bits and wdata[4] as the mode bit. The other write bits are ignored. A direction read returns the direction bits on rdata[2:0] and the mode bit on rdata[4], with every other bit 0.
- R3: With the mode bit clear, pin_oe[i] is the inverse of direction bit i from the cycle after the direction write. A direction bit of 1 means input and 0 means output.
- R4: A value write loads wdata[2:0] into the output latch whatever the direction, and pin_out shows the latch from the next cycle on.
- R5: A value read (rd_sel=0) returns, in bit i, the synchronized level of pin_in[i] ANDed with the inverse of ana_sel[i], and returns 0 in bits 7:3. A pin change reaches rdata after three clock edges: two synchronizer stages and the read register.
- R6: ana_sel has no effect on pin_oe or pin_out. Only the direction bits and the mode bit control the drivers.
- R7: With the mode bit set, pin_oe is 3'b000 and slave_ctl carries the synchronized pin levels. Bit 0 is the active-low read strobe, bit 1 the active-low write strobe and bit 2 the active-low select. With the mode bit clear, slave_ctl is 3'b111 (idle).
- R8: Reset does not clear the output latch. A value written before a reset is driven once a pin is later made an output.
- R9: rdata is registered. It shows the register chosen by rd_sel in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_val_stb | input | 1 | Write strobe for the output-value register |
| wr_dir_stb | input | 1 | Write strobe for the direction register |
| rd_sel | input | 1 | Read select: 0 value, 1 direction |
| wdata | input | 8 | Write data bus |
| rdata | output | 8 | Registered read data bus |
| pin_in | input | 3 | Pin input levels (asynchronous) |
| ana_sel | input | 3 | Per-pin analog-select mask |
| pin_out | output | 3 | Pin output values |
| pin_oe | output | 3 | Pin output enables, 1 = drive |
| slave_en | output | 1 | Parallel-slave-port mode active |
| slave_ctl | output | 3 | Synchronized active-low slave control inputs |

## Verification
The assertions assume that reset is held for at least two clock cycles. They also assume that the two write strobes are never raised in the same cycle as reset, so that each past-value comparison starts from a known register state. The stimulus raises reset from time zero for several cycles. It drives every strobe and input on the falling clock edge, one register operation at a time. pin_in and ana_sel are held stable for several cycles before each sample, so the synchronizer latency never overlaps two stimulus changes.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;
  // Position of the slave-port mode bit inside the direction register
  localparam int unsigned MODE_BIT = 4;

  // Mask pin levels with the analog-select field: analog pins read as zero
  function automatic logic [2:0] mask_analog(input logic [2:0] lvl,
                                             input logic [2:0] ana);
    return lvl & ~ana;
  endfunction
endpackage

// File: rtl/gpio3_sync.sv
module gpio3_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio3_regs.sv
module gpio3_regs #(
  parameter int unsigned NPINS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_val_stb,
  input  logic             wr_dir_stb,
  input  logic [NPINS-1:0] val_in,
  input  logic [NPINS-1:0] dir_in,
  input  logic             mode_in,
  output logic [NPINS-1:0] val_q,
  output logic [NPINS-1:0] dir_q,
  output logic             mode_q
);
  // Output latch: deliberately outside reset, keeps its content across resets
  always_ff @(posedge clk) begin
    if (wr_val_stb) val_q <= val_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      mode_q <= 1'b0;
    end else if (wr_dir_stb) begin
      dir_q  <= dir_in;
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/gpio3_rdmux.sv
module gpio3_rdmux
  import gpio3_pkg::*;
#(
  parameter int unsigned NPINS = 3,
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_sel,
  input  logic [NPINS-1:0] lvl_sync,
  input  logic [NPINS-1:0] ana_sel,
  input  logic [NPINS-1:0] dir_q,
  input  logic             mode_q,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (rd_sel) begin
      nxt[NPINS-1:0] = dir_q;
      nxt[MODE_BIT]  = mode_q;
    end else begin
      nxt[NPINS-1:0] = mask_analog(lvl_sync, ana_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/gpio3_port.sv
module gpio3_port
  import gpio3_pkg::*;
#(
  parameter int unsigned NPINS       = 3,
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_val_stb,
  input  logic             wr_dir_stb,
  input  logic             rd_sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] ana_sel,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             slave_en,
  output logic [NPINS-1:0] slave_ctl
);
  logic [NPINS-1:0] val_q, dir_q, lvl_sync;
  logic             mode_q;

  gpio3_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_sync)
  );

  gpio3_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_val_stb(wr_val_stb), .wr_dir_stb(wr_dir_stb),
    .val_in(wdata[NPINS-1:0]), .dir_in(wdata[NPINS-1:0]),
    .mode_in(wdata[MODE_BIT]),
    .val_q(val_q), .dir_q(dir_q), .mode_q(mode_q)
  );

  gpio3_rdmux #(.NPINS(NPINS), .BUS_W(BUS_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd_sel(rd_sel),
    .lvl_sync(lvl_sync), .ana_sel(ana_sel),
    .dir_q(dir_q), .mode_q(mode_q), .rdata(rdata)
  );

  // Drivers: direction bit alone decides, analog select does not intervene
  assign pin_out   = val_q;
  assign pin_oe    = mode_q ? '0 : ~dir_q;
  assign slave_en  = mode_q;
  assign slave_ctl = mode_q ? lvl_sync : '1;
endmodule

// File: rtl/gpio3_port_chk.sv
module gpio3_port_chk #(
  parameter int unsigned NPINS = 3,
  parameter int unsigned BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_val_stb,
  input logic             wr_dir_stb,
  input logic             rd_sel,
  input logic [BUS_W-1:0] wdata,
  input logic [BUS_W-1:0] rdata,
  input logic [NPINS-1:0] ana_sel,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             slave_en,
  input logic [NPINS-1:0] slave_ctl
);
  AST_DIR_SETS_OE: assert property (@(posedge clk) disable iff (rst)
    (wr_dir_stb && !wdata[4]) |=> (pin_oe == ~$past(wdata[NPINS-1:0]))); // R3

  AST_MODE_KILLS_OE: assert property (@(posedge clk) disable iff (rst)
    (wr_dir_stb && wdata[4]) |=> (pin_oe == '0 && slave_en)); // R7

  AST_IDLE_CTL: assert property (@(posedge clk) disable iff (rst)
    !slave_en |-> (slave_ctl == '1)); // R7

  AST_VAL_TO_PIN: assert property (@(posedge clk) disable iff (rst)
    wr_val_stb |=> (pin_out == $past(wdata[NPINS-1:0]))); // R4

  AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!rd_sel) |-> (rdata[BUS_W-1:NPINS] == '0 &&
                        (rdata[NPINS-1:0] & $past(ana_sel)) == '0)); // R5

  AST_OE_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_dir_stb) |-> $stable(pin_oe)); // R6
endmodule

bind gpio3_port gpio3_port_chk #(.NPINS(NPINS), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .wr_val_stb(wr_val_stb), .wr_dir_stb(wr_dir_stb),
  .rd_sel(rd_sel), .wdata(wdata), .rdata(rdata), .ana_sel(ana_sel),
  .pin_out(pin_out), .pin_oe(pin_oe), .slave_en(slave_en),
  .slave_ctl(slave_ctl)
);

// File: tb/tb_gpio3_port.sv
module tb_gpio3_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_val_stb = 1'b0, wr_dir_stb = 1'b0, rd_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] pin_in = '0, ana_sel = 3'b111;
  logic [2:0] pin_out, pin_oe, slave_ctl;
  logic       slave_en;
  int         n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  gpio3_port dut (
    .clk(clk), .rst(rst), .wr_val_stb(wr_val_stb), .wr_dir_stb(wr_dir_stb),
    .rd_sel(rd_sel), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .ana_sel(ana_sel), .pin_out(pin_out), .pin_oe(pin_oe),
    .slave_en(slave_en), .slave_ctl(slave_ctl)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_dir(input logic [7:0] v);
    wdata = v; wr_dir_stb = 1'b1; cyc(1); wr_dir_stb = 1'b0;
  endtask

  task automatic wr_val(input logic [7:0] v);
    wdata = v; wr_val_stb = 1'b1; cyc(1); wr_val_stb = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    rd_sel = sel; cyc(1); v = rdata;
  endtask

  initial begin : watchdog
    #1600000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    cyc(4); rst = 1'b0; cyc(1);
    // R1 reset state
    rd(1'b1, v); chk("R1 dir", v, 8'h07);
    chk("R1 oe", {5'b0, pin_oe}, 8'h00);
    chk("R1 ctl", {5'b0, slave_ctl}, 8'h07);
    // R3 / R2 sweep of direction codes
    for (int d = 0; d < 8; d++) begin
      wr_dir(8'hE8 | 8'(d));  // bit4 clear, junk high bits
      chk("R3 oe", {5'b0, pin_oe}, 8'(~d & 7));
      rd(1'b1, v); chk("R2 dir read", v, 8'(d));
    end
    wr_dir(8'hFA);
    rd(1'b1, v); chk("R2 mode read", v, 8'h12);
    chk("R7 oe off", {5'b0, pin_oe}, 8'h00);
    chk("R7 en", {7'b0, slave_en}, 8'h01);
    // R7 slave control sweep
    for (int p = 0; p < 8; p++) begin
      pin_in = 3'(p); cyc(3);
      chk("R7 ctl", {5'b0, slave_ctl}, 8'(p));
    end
    wr_dir(8'h07);
    chk("R7 idle", {5'b0, slave_ctl}, 8'h07);
    // R4: latch loads while input, shows once output
    for (int d = 0; d < 8; d++) begin
      wr_dir(8'h07);
      wr_val(8'hF8 | 8'(d));
      chk("R4 out", {5'b0, pin_out}, 8'(d));
      wr_dir(8'h00);
      chk("R4 oe", {5'b0, pin_oe}, 8'h07);
    end
    // R6 analog does not touch drivers
    wr_dir(8'h05); wr_val(8'h03);
    for (int a = 0; a < 8; a++) begin
      ana_sel = 3'(a); cyc(2);
      chk("R6 oe", {5'b0, pin_oe}, 8'h02);
      chk("R6 out", {5'b0, pin_out}, 8'h03);
    end
    // R5 exhaustive pins x analog
    rd_sel = 1'b0;
    for (int p = 0; p < 8; p++)
      for (int a = 0; a < 8; a++) begin
        pin_in = 3'(p); ana_sel = 3'(a); cyc(4);
        chk("R5 read", rdata, 8'(p & ~a & 7));
      end
    // R5 latency: visible after three edges, not after two
    ana_sel = 3'b000; pin_in = 3'b000; cyc(4);
    pin_in = 3'b101; cyc(2);
    chk("R5 early", rdata, 8'h00);
    cyc(1);
    chk("R5 late", rdata, 8'h05);
    // R9 registered read select
    rd_sel = 1'b1; cyc(1);
    chk("R9 dir", rdata, 8'h05);
    rd_sel = 1'b0; cyc(1);
    chk("R9 val", rdata, 8'h05);
    // R8 latch survives reset
    wr_dir(8'h07); wr_val(8'h06);
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
    chk("R8 oe after rst", {5'b0, pin_oe}, 8'h00);
    wr_dir(8'h00);
    chk("R8 out", {5'b0, pin_out}, 8'h06);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule